// File: doc/BRIEF.md
# Dual-Channel Interleaved Output Stage

This block takes two conversion words, one for each of two channels, captured together on each rising clock edge. It puts both onto one shared data bus, so each word holds the bus for half a clock period. Channel A drives the bus while the clock is high and channel B while it is low. A channel flag marks which channel owns the bus at any moment. The words arrive in offset binary. A format select can re-code them to two's complement at the bus.

An active-low output enable releases the bus. A release is shown as a deasserted valid signal with the data and flag forced to zero. A power-down request freezes the latency pipelines and holds the last word seen on the bus. After power-down ends, or after reset, the bus reports invalid until fresh samples have worked their way through the full latency.

Top module: `dual_lane_bus_mux`

## Requirements
- R1: A channel-A word captured on rising edge k is on `bus_q` with `lane_flag` = 1 during the high clock phase that follows rising edge k+5.
- R2: The channel-B word captured on the same edge k is on `bus_q` with `lane_flag` = 0 during the low clock phase that follows falling edge k+5.5.
- R3: While the bus is valid and not powered down, `lane_flag` is 1 in the high clock phase and 0 in the low clock phase.
- R4: With `fmt_twos` = 0 the captured word is passed unchanged (offset binary). With `fmt_twos` = 1 bit 9 is inverted, so 0x200 becomes 0x000, 0x3FF becomes 0x1FF and 0x000 becomes 0x200. The select acts on the bus at once, including on a held word.
- R5: While `bus_valid` is 0, `bus_q` is 0 and `lane_flag` is 0. While `oe_n` is 1, `bus_valid` is 0.
- R6: When `pwr_dn` is high at a rising edge, `bus_q` holds the word driven in the low phase just before that edge, with `lane_flag` = 0, until a rising edge sees `pwr_dn` low. Samples presented in this time are ignored.
- R7: After reset, and after each power-down, `bus_valid` stays 0 until the sixth consecutive rising edge with `pwr_dn` low. From that edge on it is 1, provided `oe_n` is 0.
- R8: During reset `bus_valid`, `bus_q` and `lane_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; both edges are used at the output |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_a | input | 10 | Channel A word, offset binary, captured on the rising edge |
| samp_b | input | 10 | Channel B word, offset binary, captured on the rising edge |
| fmt_twos | input | 1 | 0: offset binary on the bus, 1: two's complement |
| oe_n | input | 1 | Active-low output enable |
| pwr_dn | input | 1 | Power-down request, sampled on the rising edge |
| bus_q | output | 10 | Shared data bus, zero while not valid |
| bus_valid | output | 1 | 1 when the bus is driven (models the high-impedance release) |
| lane_flag | output | 1 | 1 while channel A owns the bus, 0 for channel B |

## Verification
A word captured at rising edge k is due on the bus in two places. The A word appears in the high phase after edge k+5. The B word appears in the low phase after the falling edge half a cycle later. Valid returns on the sixth rising edge with power-down low.

The bench drives its inputs 2 ns after each rising edge. It checks the high phase 5 ns after the rising edge and the low phase 5 ns after the falling edge, so every register on the way has settled. Format select and output enable act without a register, so each check compares against the select and enable values driven in that same cycle.

A bench-side model logs every captured pair by edge number. It counts consecutive fresh edges and records the word held at each power-down entry. From these it gives the expected valid, data and flag for each half-cycle.

// File: rtl/dlm_pkg.sv
package dlm_pkg;
  typedef enum logic {
    FMT_OFFSET = 1'b0,
    FMT_TWOS   = 1'b1
  } code_fmt_e;

  // Edges with the pipeline advancing needed before the bus holds fresh data.
  function automatic int fill_edges(input int latency);
    return latency + 1;
  endfunction
endpackage

// File: rtl/dlm_lane_pipe.sv
module dlm_lane_pipe #(
  parameter int W     = 10,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic [W-1:0] din,
  output logic [W-1:0] tap
);
  logic [W-1:0] stage [DEPTH];

  generate
    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stage[s] <= '0;
        end else if (!hold) begin
          if (s == 0) stage[s] <= din;
          else        stage[s] <= stage[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  assign tap = stage[DEPTH-1];
endmodule

// File: rtl/dlm_fill_tracker.sv
module dlm_fill_tracker #(
  parameter int LATENCY = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic full
);
  import dlm_pkg::*;
  localparam int TARGET = fill_edges(LATENCY);
  localparam int CW     = $clog2(TARGET + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt <= '0;
    else if (hold)                       cnt <= '0;
    else if (cnt != CW'(TARGET))         cnt <= cnt + 1'b1;
  end

  assign full = (cnt == CW'(TARGET));

  // A power-down edge always empties the fill count (R7).
  assert_no_fill_after_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !full);
endmodule

// File: rtl/dual_lane_bus_mux.sv
module dual_lane_bus_mux #(
  parameter int DATA_W  = 10,
  parameter int LATENCY = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] samp_a,
  input  logic [DATA_W-1:0] samp_b,
  input  logic              fmt_twos,
  input  logic              oe_n,
  input  logic              pwr_dn,
  output logic [DATA_W-1:0] bus_q,
  output logic              bus_valid,
  output logic              lane_flag
);
  import dlm_pkg::*;
  localparam int LANES = 2;

  // Re-code an offset-binary word into the selected bus format.
  function automatic logic [DATA_W-1:0] recode(input logic [DATA_W-1:0] w,
                                               input code_fmt_e f);
    logic [DATA_W-1:0] r;
    r = w;
    if (f == FMT_TWOS) r[DATA_W-1] = ~w[DATA_W-1];
    return r;
  endfunction

  logic [DATA_W-1:0] lane_in  [LANES];
  logic [DATA_W-1:0] lane_tap [LANES];

  assign lane_in[0] = samp_a;
  assign lane_in[1] = samp_b;

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      dlm_lane_pipe #(.W(DATA_W), .DEPTH(LATENCY)) lane_i (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (pwr_dn),
        .din  (lane_in[g]),
        .tap  (lane_tap[g])
      );
    end
  endgenerate

  logic fill_full;
  dlm_fill_tracker #(.LATENCY(LATENCY)) fill_i (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (pwr_dn),
    .full (fill_full)
  );

  // Half-cycle output registers: A on the rising edge, B staged then moved on the falling edge.
  logic [DATA_W-1:0] hi_word, lo_stage, lo_word;
  logic              pd_q, frz_ok;
  logic [DATA_W-1:0] frz_word;
  logic              pd_entry;

  assign pd_entry = pwr_dn && !pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_word  <= '0;
      lo_stage <= '0;
      pd_q     <= 1'b0;
      frz_word <= '0;
      frz_ok   <= 1'b0;
    end else begin
      pd_q <= pwr_dn;
      if (!pwr_dn) begin
        hi_word  <= lane_tap[0];
        lo_stage <= lane_tap[1];
      end
      if (pd_entry) begin
        frz_word <= lo_word;
        frz_ok   <= fill_full;
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)     lo_word <= '0;
    else if (!pd_q) lo_word <= lo_stage;
  end

  logic              word_ok;
  logic [DATA_W-1:0] raw_word;

  always_comb begin
    word_ok   = pd_q ? frz_ok : fill_full;
    bus_valid = !oe_n && word_ok;
    if (pd_q)     raw_word = frz_word;
    else if (clk) raw_word = hi_word;
    else          raw_word = lo_word;
    bus_q     = bus_valid ? recode(raw_word, code_fmt_e'(fmt_twos)) : '0;
    lane_flag = bus_valid && !pd_q && clk;
  end

  assert_idle_bus_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |-> (bus_q == '0) && !lane_flag);

  assert_oe_releases_R5: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !bus_valid);

  assert_hold_word_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_q && $past(pd_q)) |-> $stable(frz_word));

  assert_pd_flag_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |-> !lane_flag);

  assert_fill_blocks_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_q && !fill_full) |-> !bus_valid);
endmodule

// File: tb/dual_lane_bus_mux_tb.sv
module dual_lane_bus_mux_tb_top;
  localparam int W = 10;
  localparam int HIST = 4096;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] samp_a = '0, samp_b = '0;
  logic         fmt_twos = 1'b0, oe_n = 1'b0, pwr_dn = 1'b0;
  logic [W-1:0] bus_q;
  logic         bus_valid, lane_flag;

  always #10 clk = ~clk;

  dual_lane_bus_mux #(.DATA_W(W), .LATENCY(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .samp_a(samp_a), .samp_b(samp_b),
    .fmt_twos(fmt_twos), .oe_n(oe_n), .pwr_dn(pwr_dn),
    .bus_q(bus_q), .bus_valid(bus_valid), .lane_flag(lane_flag)
  );

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  // Bench-side model state
  logic [W-1:0] hist_a [HIST];
  logic [W-1:0] hist_b [HIST];
  int           edge_n = 0, fresh = 0;
  bit           in_pd = 0, held_ok = 0, last_lo_ok = 0;
  logic [W-1:0] held = '0, last_lo = '0;

  function automatic logic [W-1:0] shown(input logic [W-1:0] v, input bit twos);
    if (!twos) return v;
    return (v >= 10'd512) ? v - 10'd512 : v + 10'd512;
  endfunction

  task automatic check(input string tag, input bit ev, input logic [W-1:0] ed, input bit ef);
    n_checks++;
    if (bus_valid !== ev || bus_q !== ed || lane_flag !== ef) begin
      n_fail++;
      $display("FAIL %s edge %0d: valid/bus/flag = %0b/%h/%0b, expected %0b/%h/%0b",
               tag, edge_n, bus_valid, bus_q, lane_flag, ev, ed, ef);
    end
  endtask

  task automatic phase_check(input bit high);
    bit ok; logic [W-1:0] w; bit ev; string tag;
    if (in_pd) begin
      ok = held_ok; w = held; tag = "R6 R4";
    end else begin
      ok = (fresh >= 6);
      w  = ok ? (high ? hist_a[edge_n-5] : hist_b[edge_n-5]) : '0;
      tag = !ok ? "R7" : (high ? "R1 R3 R4" : "R2 R3 R4");
    end
    ev = ok && !oe_n;
    if (oe_n) tag = "R5";
    if (!ev) check(tag, 1'b0, '0, 1'b0);
    else     check(tag, 1'b1, shown(w, fmt_twos), high && !in_pd);
    if (!high && !in_pd) begin
      last_lo = w; last_lo_ok = ok;
    end
  endtask

  // One clock: model the edge with the inputs it captures, drive next inputs, check both phases.
  task automatic step(input logic [W-1:0] a, input logic [W-1:0] b,
                      input bit fmt, input bit oe, input bit pd);
    @(posedge clk);
    edge_n++;
    if (pwr_dn) begin
      if (!in_pd) begin held = last_lo; held_ok = last_lo_ok; end
      in_pd = 1; fresh = 0;
    end else begin
      in_pd = 0;
      if (fresh < 6) fresh++;
    end
    hist_a[edge_n] = samp_a;
    hist_b[edge_n] = samp_b;
    #2;
    samp_a = a; samp_b = b; fmt_twos = fmt; oe_n = oe; pwr_dn = pd;
    #3;
    phase_check(1'b1);
    @(negedge clk);
    #5;
    phase_check(1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R8", 1'b0, '0, 1'b0);
    @(posedge clk);
    #2 rst_n = 1'b1;
    // Full code sweep in offset binary, then in two's complement (R1 R2 R4)
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < 1024; i++)
        step(W'(i), W'(1023 - i), p[0], 1'b0, 1'b0);
    // Output enable released in bursts (R5)
    for (int i = 0; i < 60; i++)
      step(W'(i * 37), W'(i * 11 + 5), i[2], (i % 7) < 2, 1'b0);
    // Power-down windows of varied length, then refill (R6 R7)
    for (int k = 1; k < 9; k++) begin
      for (int i = 0; i < 8; i++) step(W'(k * 100 + i), W'(k * 50 + 3 * i), k[0], 1'b0, 1'b0);
      for (int i = 0; i < k; i++) step(W'(999 - i), W'(i), i[0], (k == 5 && i == 1), 1'b1);
    end
    // Power-down entered before the pipe has filled, and with outputs released (R6 R7 R5)
    step(10'h3FF, 10'h000, 1'b1, 1'b0, 1'b0);
    step(10'h200, 10'h1FF, 1'b1, 1'b0, 1'b1);
    step(10'h111, 10'h222, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 12; i++) step(W'(i * 80), W'(i * 90), 1'b1, 1'b0, 1'b0);
    step(10'h155, 10'h2AA, 1'b0, 1'b1, 1'b1);
    step(10'h155, 10'h2AA, 1'b0, 1'b1, 1'b1);
    for (int i = 0; i < 10; i++) step(W'(i * 3), W'(i * 5), 1'b0, 1'b0, 1'b0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule